// File: doc/BRIEF.md
# Segmented LRU Victim Selector

This block keeps the replacement state of one cache set with a parameterised number of ways (16 by default) and names the way to evict. Every way holds a recency rank, where 0 is most recent and WAYS-1 is least recent, and a protect flag. A set flag places the way in the protected segment. A clear flag places it in the probationary segment. Probationary ways are evicted first, so a line that has been reused survives a stream of single-use fills. When every way is protected, the least recent way overall is evicted.

The cache controller reports hits on `hit_valid`/`hit_way`. It requests a fill with the valid/ready pair `alloc_valid`/`alloc_ready`. The fill goes into the way shown on `victim_way` in the cycle of the handshake. `victim_way` depends only on stored state, so the controller can read it before it raises `alloc_valid`. A hit has priority over a fill. While `hit_valid` is high, `alloc_ready` is low. The fill then waits, and it must keep `alloc_valid` high until `alloc_ready` returns. Two features shape the protect flags and each has its own enable. Random promotion protects a new line with probability 1/2^`promo_exp`. Aging clears the flag of the least recent way on every fill.

Top module: `slru_victim_sel`

## Requirements
- R1: The ranks always form a permutation of 0..WAYS-1. After reset, way i holds rank i and every protect flag is clear.
- R2: A hit on way w sets the protect flag of w and gives w rank 0. Every way whose rank was smaller than w's old rank moves up by one rank. The others keep their rank.
- R3: When at least one protect flag is clear, `victim_way` is the unprotected way with the largest rank.
- R4: When every protect flag is set, `victim_way` is the way with rank WAYS-1.
- R5: An accepted fill (`alloc_valid` and `alloc_ready` high at a rising edge) goes into the way shown on `victim_way`. That way gets rank 0 and the other ways age as in R2. Its protect flag is cleared unless it is promoted.
- R6: With `promo_en` high, a filled way is promoted (flag set) exactly when the low `promo_exp` bits of `rnd` are all zero. Higher bits of `rnd` are ignored, and `promo_exp` = 0 always promotes. With `promo_en` low, no fill is promoted.
- R7: With `age_en` high, an accepted fill also clears the protect flag of the way that held rank WAYS-1 before the fill. If that way is itself the victim, R6 decides its flag. With `age_en` low, a fill touches no other flag.
- R8: `alloc_ready` is the inverse of `hit_valid`. A fill offered while a hit is present has no effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit is reported this cycle |
| hit_way | input | WAY_W (4) | Way that hit |
| alloc_valid | input | 1 | Fill request |
| alloc_ready | output | 1 | Fill accepted when high together with alloc_valid |
| promo_en | input | 1 | Random promotion enable |
| promo_exp | input | EXP_W (5) | Promotion probability exponent (1/2^n) |
| age_en | input | 1 | Aging enable |
| rnd | input | RND_W (16) | Random source sampled on an accepted fill |
| victim_way | output | WAY_W (4) | Way to evict / fill next |

## Verification
The bench targets a victim that is itself the least recent way while aging is on. A design that ages after placing the fill would wrongly clear a promoted line, and later victims would differ. It promotes with `rnd` values that have only high bits set, and with exponent zero. A design that masks the wrong width would leave the new line unprotected and evict it too early. It reports hits and fills in the same cycle to show that the stalled fill leaves the state unchanged. It also protects every way, where a design that still looks only at unprotected ways would name a wrong or stale victim. A long mixed sequence compares every victim against a model, so any rank update that breaks the permutation shows up as a divergence.

// File: rtl/slru_pkg.sv
package slru_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_HIT   = 2'd1,
    UPD_ALLOC = 2'd2
  } upd_kind_e;

  function automatic int unsigned clog2_min1(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/slru_rank_ctrl.sv
module slru_rank_ctrl #(
  parameter int WAYS  = 16,
  parameter int WAY_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        upd_en,
  input  logic [WAY_W-1:0]            upd_way,
  output logic [WAYS-1:0][WAY_W-1:0]  rank_q
);
  logic [WAY_W-1:0]           pivot;
  logic [WAYS-1:0][WAY_W-1:0] rank_d;

  assign pivot = rank_q[upd_way];

  always_comb begin
    rank_d = rank_q;
    if (upd_en) begin
      for (int i = 0; i < WAYS; i++) begin
        if (WAY_W'(i) == upd_way)
          rank_d[i] = '0;
        else if (rank_q[i] < pivot)
          rank_d[i] = rank_q[i] + WAY_W'(1);
      end
    end
  end

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_rank
      always_ff @(posedge clk) begin
        if (!rst_n) rank_q[g] <= WAY_W'(g);
        else        rank_q[g] <= rank_d[g];
      end
    end
  endgenerate
endmodule

// File: rtl/slru_ref_ctrl.sv
module slru_ref_ctrl #(
  parameter int WAYS  = 16,
  parameter int WAY_W = 4,
  parameter int RND_W = 16,
  parameter int EXP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slru_pkg::upd_kind_e kind,
  input  logic [WAY_W-1:0]  way,
  input  logic [WAY_W-1:0]  lru_way,
  input  logic              promo_en,
  input  logic [EXP_W-1:0]  promo_exp,
  input  logic              age_en,
  input  logic [RND_W-1:0]  rnd,
  output logic [WAYS-1:0]   ref_q
);
  import slru_pkg::*;

  logic [RND_W-1:0] mask;
  logic             promote;
  logic [WAYS-1:0]  ref_d;

  always_comb begin
    if (int'(promo_exp) >= RND_W) mask = '1;
    else                          mask = ~({RND_W{1'b1}} << promo_exp);
  end

  assign promote = promo_en && ((rnd & mask) == '0);

  always_comb begin
    ref_d = ref_q;
    case (kind)
      UPD_HIT: ref_d[way] = 1'b1;
      UPD_ALLOC: begin
        if (age_en) ref_d[lru_way] = 1'b0;
        ref_d[way] = promote;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end
endmodule

// File: rtl/slru_victim_pick.sv
module slru_victim_pick #(
  parameter int WAYS  = 16,
  parameter int WAY_W = 4
) (
  input  logic [WAYS-1:0][WAY_W-1:0] rank_q,
  input  logic [WAYS-1:0]            ref_q,
  output logic [WAY_W-1:0]           victim_way,
  output logic [WAY_W-1:0]           lru_way
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic             any_free;
  logic [WAY_W-1:0] best_way;
  logic [WAY_W-1:0] best_rank;

  always_comb begin
    lru_way = '0;
    for (int i = 0; i < WAYS; i++)
      if (rank_q[i] == OLDEST) lru_way = WAY_W'(i);
  end

  always_comb begin
    any_free  = 1'b0;
    best_way  = '0;
    best_rank = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!ref_q[i] && (!any_free || rank_q[i] > best_rank)) begin
        any_free  = 1'b1;
        best_way  = WAY_W'(i);
        best_rank = rank_q[i];
      end
    end
  end

  assign victim_way = any_free ? best_way : lru_way;
endmodule

// File: rtl/slru_victim_sel.sv
module slru_victim_sel #(
  parameter int WAYS  = 16,
  parameter int RND_W = 16,
  parameter int WAY_W = slru_pkg::clog2_min1(WAYS),
  parameter int EXP_W = slru_pkg::clog2_min1(RND_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_valid,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic             promo_en,
  input  logic [EXP_W-1:0] promo_exp,
  input  logic             age_en,
  input  logic [RND_W-1:0] rnd,
  output logic [WAY_W-1:0] victim_way
);
  import slru_pkg::*;

  logic [WAYS-1:0][WAY_W-1:0] rank_q;
  logic [WAYS-1:0]            ref_q;
  logic [WAY_W-1:0]           lru_way;
  logic                       accept;
  upd_kind_e                  kind;
  logic [WAY_W-1:0]           upd_way;

  assign alloc_ready = !hit_valid;
  assign accept      = alloc_valid && alloc_ready;

  always_comb begin
    if (hit_valid) begin
      kind    = UPD_HIT;
      upd_way = hit_way;
    end else if (accept) begin
      kind    = UPD_ALLOC;
      upd_way = victim_way;
    end else begin
      kind    = UPD_NONE;
      upd_way = '0;
    end
  end

  slru_rank_ctrl #(.WAYS(WAYS), .WAY_W(WAY_W)) u_rank (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (kind != UPD_NONE),
    .upd_way (upd_way),
    .rank_q  (rank_q)
  );

  slru_ref_ctrl #(.WAYS(WAYS), .WAY_W(WAY_W), .RND_W(RND_W), .EXP_W(EXP_W)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (kind),
    .way       (upd_way),
    .lru_way   (lru_way),
    .promo_en  (promo_en),
    .promo_exp (promo_exp),
    .age_en    (age_en),
    .rnd       (rnd),
    .ref_q     (ref_q)
  );

  slru_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
    .rank_q     (rank_q),
    .ref_q      (ref_q),
    .victim_way (victim_way),
    .lru_way    (lru_way)
  );
endmodule

// File: rtl/slru_victim_sel_chk.sv
module slru_victim_sel_chk #(
  parameter int WAYS  = 16,
  parameter int WAY_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hit_valid,
  input logic [WAY_W-1:0]           hit_way,
  input logic                       alloc_ready,
  input logic [WAY_W-1:0]           victim_way,
  input logic [WAYS-1:0][WAY_W-1:0] rank_q,
  input logic [WAYS-1:0]            ref_q
);
  logic [WAYS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < WAYS; i++) seen[rank_q[i]] = 1'b1;
  end

  a_r1_rank_perm: assert property (@(posedge clk) disable iff (!rst_n) seen == '1);

  a_r2_hit_protects: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |=> ref_q[$past(hit_way)]);

  a_r2_hit_mru: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |=> rank_q[$past(hit_way)] == '0);

  a_r3_victim_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ref_q) |-> !ref_q[victim_way]);

  a_r4_all_protected_lru: assert property (@(posedge clk) disable iff (!rst_n)
    (&ref_q) |-> rank_q[victim_way] == WAY_W'(WAYS - 1));

  a_r8_hit_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> !alloc_ready);
endmodule

bind slru_victim_sel slru_victim_sel_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hit_valid   (hit_valid),
  .hit_way     (hit_way),
  .alloc_ready (alloc_ready),
  .victim_way  (victim_way),
  .rank_q      (rank_q),
  .ref_q       (ref_q)
);

// File: tb/tb_slru_victim_sel.sv
module tb_slru_victim_sel;
  localparam int WAYS = 16, RND_W = 16, WAY_W = 4, EXP_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hit_valid = 0, alloc_valid = 0, promo_en = 0, age_en = 0;
  logic [WAY_W-1:0] hit_way = '0;
  logic [EXP_W-1:0] promo_exp = '0;
  logic [RND_W-1:0] rnd = '0;
  logic alloc_ready;
  logic [WAY_W-1:0] victim_way;

  always #10 clk = ~clk;

  slru_victim_sel dut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_way(hit_way),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .promo_en(promo_en),
    .promo_exp(promo_exp), .age_en(age_en), .rnd(rnd), .victim_way(victim_way)
  );

  int checks = 0, fails = 0;
  int m_rank[WAYS];
  bit m_ref[WAYS];
  int exp_q[$];
  string tag_q[$];
  bit done = 0;

  function automatic int m_victim();
    int best = -1;
    for (int i = 0; i < WAYS; i++)
      if (!m_ref[i] && (best < 0 || m_rank[i] > m_rank[best])) best = i;
    if (best < 0)
      for (int i = 0; i < WAYS; i++) if (m_rank[i] == WAYS - 1) best = i;
    return best;
  endfunction

  function automatic void m_touch(int w);
    int old = m_rank[w];
    for (int i = 0; i < WAYS; i++)
      if (i == w) m_rank[i] = 0;
      else if (m_rank[i] < old) m_rank[i]++;
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: one operation per cycle; expected victim goes to scoreboard
  task automatic op(bit h, int hw, bit a, bit pe, int pexp, bit ae, int r, string tag);
    bit prom;
    int v, lru;
    @(negedge clk);
    hit_valid = h; hit_way = WAY_W'(hw); alloc_valid = a;
    promo_en = pe; promo_exp = EXP_W'(pexp); age_en = ae; rnd = RND_W'(r);
    #1 check({tag, " R8 ready"}, int'(alloc_ready), int'(!h));
    @(posedge clk);
    v = m_victim();
    lru = 0;
    for (int i = 0; i < WAYS; i++) if (m_rank[i] == WAYS - 1) lru = i;
    if (h) begin
      m_ref[hw] = 1; m_touch(hw);
    end else if (a) begin
      prom = pe && ((pexp >= RND_W) ? (r[RND_W-1:0] == 0) : ((r & ((1 << pexp) - 1)) == 0));
      if (ae) m_ref[lru] = 0;
      m_ref[v] = prom;
      m_touch(v);
    end
    #1;
    hit_valid = 0; alloc_valid = 0;
    exp_q.push_back(m_victim());
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " victim"}, int'(victim_way), e);
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < WAYS; i++) begin m_rank[i] = i; m_ref[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 reset victim", int'(victim_way), WAYS - 1);
    // R5 plain fills walk the ranks; R3 unprotected oldest chosen
    op(0, 0, 1, 0, 0, 0, 0, "R5 fill");
    op(0, 0, 1, 0, 0, 0, 0, "R3 fill");
    // R2 hits protect ways
    op(1, 13, 0, 0, 0, 0, 0, "R2 hit13");
    op(1, 12, 0, 0, 0, 0, 0, "R2 hit12");
    op(0, 0, 1, 0, 0, 0, 0, "R3 skip protected");
    // R8 simultaneous hit and fill
    op(1, 2, 1, 0, 0, 0, 0, "R8 collide");
    // R6 promotion: high bits ignored, low bits nonzero blocks, exp 0 always
    op(0, 0, 1, 1, 5, 0, 16'h0020, "R6 promote high");
    op(0, 0, 1, 1, 5, 0, 16'h0001, "R6 no promote");
    op(0, 0, 1, 1, 0, 0, 16'hFFFF, "R6 exp0");
    op(0, 0, 1, 0, 0, 0, 0, "R6 disabled");
    // R4 protect every way
    for (int i = 0; i < WAYS; i++) op(1, i, 0, 0, 0, 0, 0, "R4 hit all");
    op(0, 0, 0, 0, 0, 0, 0, "R4 all protected");
    // R7 aging with victim = LRU and promotion
    op(0, 0, 1, 1, 0, 1, 0, "R7 age self");
    op(0, 0, 1, 0, 0, 1, 0, "R7 age");
    op(0, 0, 1, 0, 0, 1, 0, "R7 age2");
    op(0, 0, 1, 0, 0, 0, 0, "R7 no age");
    // mixed run
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op(lfsr[0], int'(lfsr[7:4]), lfsr[1] | lfsr[2], lfsr[3], int'(lfsr[10:8]),
         lfsr[11], int'(lfsr ^ 16'h5A5A), "R1 mixed");
    end
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule